// File: doc/BRIEF.md
# ECC Error Capture and Diagnostic Logger

This block sits next to a 32-bit flow-through error detection and correction datapath and keeps a record of what that datapath has seen. A syndrome generator outside the block supplies a per-word syndrome, an error flag and a multiple-error flag. It also supplies the raw memory word with its per-byte parity bits and the checkbits it generated. A syndrome strobe, gated by an active-low enable, marks the moments when the logger should look at these inputs.

After an active-low clear, the first strobed error loads three registers: the syndrome, the uncorrected memory word and a two-bit error type. Every strobed error, including that first one, advances a four-bit counter that stops at fifteen. A three-bit mode select sets what the block drives. It sets the diagnostic bus contents, which is either the packed syndrome, counter and type, or the captured word. After a clear, the captured word is all zeros and can be used to initialize memory. The mode also decides whether the checkbits passed to the datapath are generated or injected from the system bus, and whether correction is enabled.

The strobe is sampled in the system clock domain, and a capture or count happens on a detected rising edge. The three error indications are active low and purely combinational.

Top module: `ecc_diag_logger`

## Requirements
- R1: On a strobe event with errFlag high and the counter at zero, the syndrome register loads syndrome, the error-data register loads memData, and the type register loads 2'b10 if multiFlag is high, otherwise 2'b01. While the counter is non-zero, these three registers hold. A strobe event is a low-to-high change of synClk between two rising edges of clk, seen while synClkEnN is low.
- R2: Each strobe event with errFlag high adds one to the counter, which saturates at 15. A strobe event with errFlag low changes nothing. A synClk held high counts only once.
- R3: A rise of synClk while synClkEnN is high is ignored, for both capture and counting.
- R4: A rising clk edge with clearN low sets the syndrome, error-data, counter and type registers to zero. This takes priority over a strobe event in the same cycle.
- R5: With mode[1:0]=01 (diagnostic output), diagBus is zero except for these fields: bits 7..0 hold the syndrome register, bits 11..8 the counter and bits 13..12 the type register.
- R6: With mode=000 (error-data output), diagBus presents the error-data register. After a clear, this is all zeros.
- R7: With mode=100 (checkbit injection), checkOut equals sysLow. In every other mode, checkOut equals genCheck.
- R8: correctEn is high only for mode[1:0]=11.
- R9: In modes x11, x10 and 100, diagBus is zero.
- R10: errN is the inverse of errFlag and merrN is the inverse of multiFlag, combinationally.
- R11: perrN is low when at least one byte i has byteEn[i] high and an odd XOR over memData[8i+7:8i] together with memParity[i]. Bytes with byteEn[i] low never cause a parity error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| syndrome | input | 8 | Syndrome of the current word |
| errFlag | input | 1 | Error detected on current word (high) |
| multiFlag | input | 1 | Uncorrectable error on current word (high) |
| memData | input | 32 | Raw uncorrected memory word |
| memParity | input | 4 | Per-byte parity bits |
| byteEn | input | 4 | Byte enables for the parity check |
| genCheck | input | 8 | Checkbits generated by the datapath |
| sysLow | input | 8 | Low byte of the system data bus |
| synClk | input | 1 | Syndrome strobe |
| synClkEnN | input | 1 | Strobe enable, active low |
| clearN | input | 1 | Synchronous clear, active low |
| mode | input | 3 | Operating mode select |
| errN | output | 1 | Error indication, active low |
| merrN | output | 1 | Multiple-error indication, active low |
| perrN | output | 1 | Parity-error indication, active low |
| correctEn | output | 1 | Correction enable to the datapath |
| checkOut | output | 8 | Checkbits used by the datapath |
| diagBus | output | 32 | Diagnostic readout bus |

## Verification
The assertions assume the following about the inputs:
- synClk and synClkEnN are synchronous to clk.
- clearN is a clean synchronous level.
- rst_n is held low until after the first clock edge.

The bench meets these assumptions by changing every input only at falling clk edges. It pulses synClk for exactly one clock period, except for the one case that deliberately holds it high. It keeps the mode select stable while the strobe is active, so every readout is taken from settled registers.

// File: rtl/ecc_diag_pkg.sv
package ecc_diag_pkg;
  typedef struct packed {
    logic clear;
    logic capture;
    logic count;
  } eccStrobe_t;

  localparam logic [1:0] TYPE_NONE   = 2'b00;
  localparam logic [1:0] TYPE_SINGLE = 2'b01;
  localparam logic [1:0] TYPE_MULTI  = 2'b10;

  function automatic logic isDiagMode(input logic [2:0] m);
    return m[1:0] == 2'b01;
  endfunction

  function automatic logic isDataMode(input logic [2:0] m);
    return m == 3'b000;
  endfunction

  function automatic logic isInjectMode(input logic [2:0] m);
    return m == 3'b100;
  endfunction

  function automatic logic isCorrectMode(input logic [2:0] m);
    return m[1:0] == 2'b11;
  endfunction
endpackage

// File: rtl/ecc_diag_ctrl.sv
module ecc_diag_ctrl
  import ecc_diag_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       synClk,
  input  logic       synClkEnN,
  input  logic       clearN,
  input  logic       errFlag,
  input  logic       cntZero,
  input  logic       cntSat,
  output eccStrobe_t strobe
);
  logic synPrev;
  logic edgeEv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) synPrev <= 1'b0;
    else        synPrev <= synClk;
  end

  assign edgeEv = synClk & ~synPrev & ~synClkEnN;

  always_comb begin
    strobe.clear   = ~clearN;
    strobe.capture = edgeEv & errFlag & cntZero;
    strobe.count   = edgeEv & errFlag & ~cntSat;
  end
endmodule

// File: rtl/ecc_diag_dpath.sv
module ecc_diag_dpath
  import ecc_diag_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SYN_W  = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  eccStrobe_t        strobe,
  input  logic [SYN_W-1:0]  syndrome,
  input  logic              multiFlag,
  input  logic [DATA_W-1:0] memData,
  input  logic [2:0]        mode,
  output logic [SYN_W-1:0]  synQ,
  output logic [DATA_W-1:0] dataQ,
  output logic [CNT_W-1:0]  cntQ,
  output logic [1:0]        typeQ,
  output logic              cntZero,
  output logic              cntSat,
  output logic [DATA_W-1:0] diagBus
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam int PAD_W = DATA_W - SYN_W - CNT_W - 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      synQ  <= '0;
      dataQ <= '0;
      cntQ  <= '0;
      typeQ <= TYPE_NONE;
    end else if (strobe.clear) begin
      synQ  <= '0;
      dataQ <= '0;
      cntQ  <= '0;
      typeQ <= TYPE_NONE;
    end else begin
      if (strobe.capture) begin
        synQ  <= syndrome;
        dataQ <= memData;
        typeQ <= multiFlag ? TYPE_MULTI : TYPE_SINGLE;
      end
      if (strobe.count) cntQ <= cntQ + 1'b1;
    end
  end

  assign cntZero = (cntQ == '0);
  assign cntSat  = (cntQ == CNT_MAX);

  always_comb begin
    if (isDiagMode(mode))      diagBus = {{PAD_W{1'b0}}, typeQ, cntQ, synQ};
    else if (isDataMode(mode)) diagBus = dataQ;
    else                       diagBus = '0;
  end
endmodule

// File: rtl/ecc_diag_logger.sv
module ecc_diag_logger
  import ecc_diag_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SYN_W  = 8,
  parameter int CNT_W  = 4,
  localparam int BYTES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SYN_W-1:0]  syndrome,
  input  logic              errFlag,
  input  logic              multiFlag,
  input  logic [DATA_W-1:0] memData,
  input  logic [BYTES-1:0]  memParity,
  input  logic [BYTES-1:0]  byteEn,
  input  logic [SYN_W-1:0]  genCheck,
  input  logic [SYN_W-1:0]  sysLow,
  input  logic              synClk,
  input  logic              synClkEnN,
  input  logic              clearN,
  input  logic [2:0]        mode,
  output logic              errN,
  output logic              merrN,
  output logic              perrN,
  output logic              correctEn,
  output logic [SYN_W-1:0]  checkOut,
  output logic [DATA_W-1:0] diagBus
);
  eccStrobe_t        strobe;
  logic              cntZero, cntSat;
  logic [SYN_W-1:0]  synQ;
  logic [DATA_W-1:0] dataQ;
  logic [CNT_W-1:0]  cntQ;
  logic [1:0]        typeQ;
  logic [BYTES-1:0]  byteBad;

  ecc_diag_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .synClk(synClk), .synClkEnN(synClkEnN),
    .clearN(clearN), .errFlag(errFlag), .cntZero(cntZero), .cntSat(cntSat),
    .strobe(strobe)
  );

  ecc_diag_dpath #(.DATA_W(DATA_W), .SYN_W(SYN_W), .CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .syndrome(syndrome),
    .multiFlag(multiFlag), .memData(memData), .mode(mode),
    .synQ(synQ), .dataQ(dataQ), .cntQ(cntQ), .typeQ(typeQ),
    .cntZero(cntZero), .cntSat(cntSat), .diagBus(diagBus)
  );

  for (genvar i = 0; i < BYTES; i++) begin : g_par
    assign byteBad[i] = ^{memData[8*i +: 8], memParity[i]};
  end

  assign perrN     = ~|(byteBad & byteEn);
  assign errN      = ~errFlag;
  assign merrN     = ~multiFlag;
  assign correctEn = isCorrectMode(mode);
  assign checkOut  = isInjectMode(mode) ? sysLow : genCheck;
endmodule

// File: rtl/ecc_diag_chk.sv
module ecc_diag_chk #(
  parameter int DATA_W = 32,
  parameter int SYN_W  = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clearN,
  input logic              synClkEnN,
  input logic [SYN_W-1:0]  synQ,
  input logic [DATA_W-1:0] dataQ,
  input logic [CNT_W-1:0]  cntQ,
  input logic [1:0]        typeQ
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cntQ == CNT_MAX && clearN) |=> cntQ == CNT_MAX);

  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    clearN |=> (cntQ == $past(cntQ) || cntQ == $past(cntQ) + 1'b1));

  a_r4_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    !clearN |=> (cntQ == '0 && synQ == '0 && dataQ == '0 && typeQ == 2'b00));

  a_r1_first_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cntQ != '0 && clearN) |=> ($stable(synQ) && $stable(dataQ) && $stable(typeQ)));

  a_r3_enable_off: assert property (@(posedge clk) disable iff (!rst_n)
    (synClkEnN && clearN) |=> ($stable(cntQ) && $stable(synQ)));
endmodule

bind ecc_diag_logger ecc_diag_chk #(.DATA_W(DATA_W), .SYN_W(SYN_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clearN(clearN), .synClkEnN(synClkEnN),
  .synQ(synQ), .dataQ(dataQ), .cntQ(cntQ), .typeQ(typeQ)
);

// File: tb/ecc_diag_logger_tb.sv
module ecc_diag_logger_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  syndrome;
  logic        errFlag, multiFlag;
  logic [31:0] memData;
  logic [3:0]  memParity, byteEn;
  logic [7:0]  genCheck, sysLow;
  logic        synClk, synClkEnN, clearN;
  logic [2:0]  mode;
  logic        errN, merrN, perrN, correctEn;
  logic [7:0]  checkOut;
  logic [31:0] diagBus;

  int checks = 0;
  int failures = 0;
  logic [7:0]  mSyn;
  logic [31:0] mData;
  logic [3:0]  mCnt;
  logic [1:0]  mType;

  always #10 clk = ~clk;

  ecc_diag_logger u_dut (
    .clk(clk), .rst_n(rst_n), .syndrome(syndrome), .errFlag(errFlag),
    .multiFlag(multiFlag), .memData(memData), .memParity(memParity),
    .byteEn(byteEn), .genCheck(genCheck), .sysLow(sysLow), .synClk(synClk),
    .synClkEnN(synClkEnN), .clearN(clearN), .mode(mode), .errN(errN),
    .merrN(merrN), .perrN(perrN), .correctEn(correctEn), .checkOut(checkOut),
    .diagBus(diagBus)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic strobe(input logic en);
    @(negedge clk);
    synClk = 1'b1; synClkEnN = ~en;
    @(negedge clk);
    synClk = 1'b0; synClkEnN = 1'b0;
    if (en && errFlag) begin
      if (mCnt == 0) begin
        mSyn = syndrome; mData = memData; mType = multiFlag ? 2'b10 : 2'b01;
      end
      if (mCnt != 4'hF) mCnt = mCnt + 1;
    end
  endtask

  task automatic doClear();
    @(negedge clk); clearN = 1'b0;
    @(negedge clk); clearN = 1'b1;
    mSyn = 0; mData = 0; mCnt = 0; mType = 0;
  endtask

  task automatic checkRegs(input string req);
    mode = 3'b001; #1;
    check(req, diagBus, {18'b0, mType, mCnt, mSyn});
    mode = 3'b000; #1;
    check(req, diagBus, mData);
    mode = 3'b011;
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0; syndrome = 0; errFlag = 0; multiFlag = 0; memData = 0;
    memParity = 0; byteEn = 0; genCheck = 8'h3C; sysLow = 8'hC3;
    synClk = 0; synClkEnN = 0; clearN = 1; mode = 3'b011;
    mSyn = 0; mData = 0; mCnt = 0; mType = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    checkRegs("R4 reset state");

    // R1: first error captured, later ones do not overwrite
    errFlag = 1; syndrome = 8'h5A; memData = 32'hDEADBEEF;
    strobe(1'b1);
    checkRegs("R1 first capture");
    syndrome = 8'h11; memData = 32'h12345678; multiFlag = 1;
    strobe(1'b1);
    checkRegs("R1 second error held");

    // R2: saturation sweep
    for (int i = 0; i < 18; i++) begin
      strobe(1'b1);
      mode = 3'b101; #1;
      check("R2 count saturate", {28'b0, diagBus[11:8]}, {28'b0, mCnt});
      mode = 3'b011;
    end

    // R4: clear, R6: zero word after clear
    doClear();
    checkRegs("R4 clear all");
    mode = 3'b000; #1;
    check("R6 zero init word", diagBus, 32'h0);
    mode = 3'b011;

    // R3: enable off ignores strobe
    syndrome = 8'h77; multiFlag = 0;
    for (int i = 0; i < 3; i++) strobe(1'b0);
    checkRegs("R3 strobe disabled");

    // R2: errFlag low ignored
    errFlag = 0;
    strobe(1'b1);
    checkRegs("R2 no error no count");

    // R2: held high counts once; multi type capture
    errFlag = 1; multiFlag = 1; syndrome = 8'hA5; memData = 32'hCAFEF00D;
    @(negedge clk); synClk = 1;
    repeat (4) @(negedge clk);
    synClk = 0;
    mSyn = 8'hA5; mData = 32'hCAFEF00D; mType = 2'b10; mCnt = 1;
    checkRegs("R2 level counted once");

    // R4: clear wins over simultaneous strobe
    @(negedge clk); clearN = 0; synClk = 1;
    @(negedge clk); clearN = 1; synClk = 0;
    mSyn = 0; mData = 0; mCnt = 0; mType = 0;
    checkRegs("R4 clear priority");

    // R6 with captured data, R5 packing of single error
    multiFlag = 0; syndrome = 8'h3F; memData = 32'h0F0F_A0A0;
    strobe(1'b1);
    mode = 3'b000; #1;
    check("R6 error data output", diagBus, 32'h0F0F_A0A0);
    mode = 3'b001; #1;
    check("R5 diag packing", diagBus, 32'h0000_113F);

    // R7 R8 R9: mode sweep
    for (int m = 0; m < 8; m++) begin
      mode = m[2:0]; sysLow = 8'h40 + m[7:0]; genCheck = 8'h90 + m[7:0]; #1;
      check("R7 checkbit source", {24'b0, checkOut},
            {24'b0, (m == 4) ? sysLow : genCheck});
      check("R8 correct enable", {31'b0, correctEn}, {31'b0, (m % 4) == 3});
      if ((m % 4) == 3 || (m % 4) == 2 || m == 4)
        check("R9 bus idle", diagBus, 32'h0);
    end

    // R10
    for (int k = 0; k < 4; k++) begin
      errFlag = k[0]; multiFlag = k[1]; #1;
      check("R10 errN", {31'b0, errN}, {31'b0, ~k[0]});
      check("R10 merrN", {31'b0, merrN}, {31'b0, ~k[1]});
    end

    // R11: exhaustive enable x parity sweep
    memData = 32'h0103_0700;
    for (int e = 0; e < 16; e++) begin
      for (int p = 0; p < 16; p++) begin
        logic bad;
        byteEn = e[3:0]; memParity = p[3:0]; #1;
        bad = 1'b0;
        for (int b = 0; b < 4; b++)
          if (e[b] && (^memData[8*b +: 8] != p[b])) bad = 1'b1;
        check("R11 parity", {31'b0, perrN}, {31'b0, ~bad});
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule